// File: doc/BRIEF.md
# Open-Drain Bus Collision Access Controller

This block decides when one station may put a frame onto a serial bus that several stations share through open-drain drivers. Because the line is a wired-AND, a station driving 0 always wins over a station releasing the line to 1. An echo input returns the level the bus actually carries. The block compares that level with what the station is driving, and so learns whether the bus is free and whether its own transmission survives.

A framer holds `tx_bit_valid` high for as long as it has a frame to send, and presents bits on `tx_bit`. Before a frame may start, the block waits until the echo has shown a run of consecutive ones. The length of that run is programmable between 7 and 10. While the bus is granted, one framer bit is placed on the bus per clock, and each clock is one bit time. If the station drives 1 but the bus reads 0, another station has taken the line. The block then releases the line, pulses `collision` for one bit time so the framer can rewind, and goes back to waiting. The next attempt needs one more idle one than the last, up to a limit of 10. The extra ones are dropped after a frame completes.

The controller is a four-state machine:
- IDLE: nothing pending. It moves to WAIT when `tx_bit_valid` rises.
- WAIT: counting idle ones. It moves to SEND once the run, including the current cycle, reaches the threshold. It returns to IDLE if the request is withdrawn.
- SEND: the bus is granted. It moves to COLL on a mismatch. It moves to IDLE when `tx_bit_valid` falls, which counts as a successful frame.
- COLL: a single collision cycle. It moves to WAIT, or to IDLE if no request remains.

The count of consecutive echo ones runs in every state except SEND, where it is held at zero.

Top module: `bus_collision_ctrl`

## Requirements
- R1: While reset is held, `bus_grant` is 0, `bus_drive` is 1 (line released) and `collision` is 0.
- R2: With a request pending and the bus at 0, `bus_grant` rises on the clock edge that ends the cycle carrying the threshold-th consecutive 1 on `echo`, and not before.
- R3: A 0 on `echo` while waiting restarts the count of idle ones from zero.
- R4: The base threshold is `cfg_run_base` clamped to the range 7..10. Values 0..6 act as 7, and values 11..15 act as 10.
- R5: While granted with `tx_bit_valid` high, `bus_drive` equals `tx_bit` in the same cycle. Whenever the bus is not granted, `bus_drive` is 1.
- R6: If, in a granted cycle, the station drives 1 and `echo` is 0, then in the following cycle `collision` is 1, `bus_grant` is 0 and `bus_drive` is 1. `collision` is 1 for exactly one cycle.
- R7: A cycle in which the station drives 0 never produces a collision, whatever level `echo` shows.
- R8: After each collision the request stays live and the block waits again on its own. The threshold for that retry is one more than the previous one, capped at 10.
- R9: After a successful frame, the threshold returns to the clamped base value.
- R10: If `tx_bit_valid` falls while granted, `bus_grant` is 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bit time per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_run_base | input | 4 | Base count of idle ones required before access (clamped 7..10) |
| tx_bit | input | 1 | Bit offered by the framer |
| tx_bit_valid | input | 1 | Framer has a frame pending / bit offered |
| echo | input | 1 | Level currently seen on the shared bus |
| bus_drive | output | 1 | Open-drain drive level (1 = released) |
| bus_grant | output | 1 | Bus granted; framer bit consumed this cycle |
| collision | output | 1 | One-cycle pulse after a lost bit |

## Verification
`bus_drive` follows `tx_bit` within the same cycle, so the bench checks it a nanosecond after driving its inputs, with no clock edge in between. The grant is registered. It is due exactly N clock edges after the first 1 of the idle run, where N is the threshold, so the bench counts edges from that point and compares the count with the threshold it has computed itself. The collision pulse is due one edge after the mismatching cycle and must be gone after the next edge, and the grant must be gone one edge after the request drops. All outputs are read at the falling edge after the counted rising edges.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_SEND = 2'd2,
        ST_COLL = 2'd3
    } acc_state_t;

endpackage

// File: rtl/echo_run_counter.sv
// Counts consecutive ones seen on the bus echo, saturating at MAX_RUN.
// run_len includes the current cycle's echo value.
module echo_run_counter #(
    parameter int MAX_RUN = 10,
    parameter int CNT_W   = $clog2(MAX_RUN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_clear,
    input  logic             echo,
    output logic [CNT_W-1:0] run_len
);

    localparam logic [CNT_W-1:0] SAT = CNT_W'(MAX_RUN);

    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        if (!echo) begin
            run_len = '0;
        end else if (cnt_q >= SAT) begin
            run_len = SAT;
        end else begin
            run_len = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (hold_clear) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= run_len;
        end
    end

endmodule

// File: rtl/run_threshold.sv
// Clamps the configured base and adds one per collision since the last
// successful frame, with the sum capped at MAX_RUN.
module run_threshold #(
    parameter int MIN_RUN = 7,
    parameter int MAX_RUN = 10,
    parameter int CNT_W   = $clog2(MAX_RUN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_base,
    input  logic             bump,
    input  logic             restore,
    output logic [CNT_W-1:0] thr
);

    localparam int EXTRA_MAX = MAX_RUN - MIN_RUN;
    localparam int EXTRA_W   = (EXTRA_MAX < 1) ? 1 : $clog2(EXTRA_MAX + 1);
    localparam logic [CNT_W-1:0] LO = CNT_W'(MIN_RUN);
    localparam logic [CNT_W-1:0] HI = CNT_W'(MAX_RUN);
    localparam logic [EXTRA_W-1:0] EXTRA_TOP = EXTRA_W'(EXTRA_MAX);

    logic [EXTRA_W-1:0] extra_q;
    logic [CNT_W-1:0]   base_c;
    logic [CNT_W:0]     sum;

    always_comb begin
        if (cfg_base < LO) begin
            base_c = LO;
        end else if (cfg_base > HI) begin
            base_c = HI;
        end else begin
            base_c = cfg_base;
        end
        sum = {1'b0, base_c} + (CNT_W + 1)'(extra_q);
        thr = (sum > {1'b0, HI}) ? HI : sum[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            extra_q <= '0;
        end else if (restore) begin
            extra_q <= '0;
        end else if (bump && (extra_q < EXTRA_TOP)) begin
            extra_q <= extra_q + 1'b1;
        end
    end

endmodule

// File: rtl/bus_access_fsm.sv
module bus_access_fsm
    import bcc_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_bit,
    input  logic             tx_bit_valid,
    input  logic             echo,
    input  logic [CNT_W-1:0] run_len,
    input  logic [CNT_W-1:0] thr,
    output logic             bus_drive,
    output logic             bus_grant,
    output logic             collision,
    output logic             coll_evt,
    output logic             ok_evt,
    output logic             cnt_hold
);

    acc_state_t state_q, state_d;
    logic       lost_bit;

    // Driving 1 while the line reads 0: another station owns the bus.
    assign lost_bit = tx_bit_valid && tx_bit && !echo;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tx_bit_valid) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (!tx_bit_valid)      state_d = ST_IDLE;
                else if (run_len >= thr) state_d = ST_SEND;
            end
            ST_SEND: begin
                if (!tx_bit_valid)  state_d = ST_IDLE;
                else if (lost_bit)  state_d = ST_COLL;
            end
            ST_COLL: begin
                state_d = tx_bit_valid ? ST_WAIT : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        bus_drive = 1'b1;
        bus_grant = 1'b0;
        collision = 1'b0;
        coll_evt  = 1'b0;
        ok_evt    = 1'b0;
        cnt_hold  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WAIT: ;
            ST_SEND: begin
                bus_grant = 1'b1;
                cnt_hold  = 1'b1;
                bus_drive = tx_bit_valid ? tx_bit : 1'b1;
                coll_evt  = lost_bit;
                ok_evt    = !tx_bit_valid;
            end
            ST_COLL: begin
                collision = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/bus_collision_ctrl.sv
module bus_collision_ctrl #(
    parameter int MIN_RUN = 7,
    parameter int MAX_RUN = 10,
    parameter int CNT_W   = $clog2(MAX_RUN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_run_base,
    input  logic             tx_bit,
    input  logic             tx_bit_valid,
    input  logic             echo,
    output logic             bus_drive,
    output logic             bus_grant,
    output logic             collision
);

    logic [CNT_W-1:0] run_len;
    logic [CNT_W-1:0] thr;
    logic             coll_evt;
    logic             ok_evt;
    logic             cnt_hold;

    echo_run_counter #(
        .MAX_RUN (MAX_RUN),
        .CNT_W   (CNT_W)
    ) run_cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_clear (cnt_hold),
        .echo       (echo),
        .run_len    (run_len)
    );

    run_threshold #(
        .MIN_RUN (MIN_RUN),
        .MAX_RUN (MAX_RUN),
        .CNT_W   (CNT_W)
    ) thr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_base (cfg_run_base),
        .bump     (coll_evt),
        .restore  (ok_evt),
        .thr      (thr)
    );

    bus_access_fsm #(
        .CNT_W (CNT_W)
    ) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_bit       (tx_bit),
        .tx_bit_valid (tx_bit_valid),
        .echo         (echo),
        .run_len      (run_len),
        .thr          (thr),
        .bus_drive    (bus_drive),
        .bus_grant    (bus_grant),
        .collision    (collision),
        .coll_evt     (coll_evt),
        .ok_evt       (ok_evt),
        .cnt_hold     (cnt_hold)
    );

endmodule

// File: rtl/bcc_checker.sv
module bcc_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_bit,
    input logic tx_bit_valid,
    input logic echo,
    input logic bus_drive,
    input logic bus_grant,
    input logic collision
);

    // R6: a lost 1 in a granted cycle is reported on the next cycle
    a_r6_flag_after_loss: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_grant && tx_bit_valid && bus_drive && !echo) |=> collision);

    // R6: pulse lasts one cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        collision |=> !collision);

    // R6: line released and grant withdrawn during the pulse
    a_r6_release_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
        collision |-> (bus_drive && !bus_grant));

    // R7: driving 0 never leads to a collision
    a_r7_zero_never_loses: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_grant && tx_bit_valid && !tx_bit) |=> !collision);

    // R5: released line whenever not granted
    a_r5_released_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_grant |-> bus_drive);

    // R2: access starts only after a cycle in which the bus read 1
    a_r2_grant_after_one: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_grant) |-> $past(echo));

    // R10: withdrawn request drops the grant on the next cycle
    a_r10_grant_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_grant && !tx_bit_valid) |=> !bus_grant);

endmodule

bind bus_collision_ctrl bcc_checker chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_bit       (tx_bit),
    .tx_bit_valid (tx_bit_valid),
    .echo         (echo),
    .bus_drive    (bus_drive),
    .bus_grant    (bus_grant),
    .collision    (collision)
);

// File: tb/bus_collision_ctrl_tb_top.sv
`timescale 1ns/1ps
module bus_collision_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] cfg_run_base;
    logic       tx_bit;
    logic       tx_bit_valid;
    logic       echo;
    logic       bus_drive;
    logic       bus_grant;
    logic       collision;

    logic       other_bit;   // level driven by the rest of the bus
    logic       force_one;   // forces the echo high (non-physical probe)

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    // Wired-AND bus model
    assign echo = force_one ? 1'b1 : (bus_drive & other_bit);

    bus_collision_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_run_base (cfg_run_base),
        .tx_bit       (tx_bit),
        .tx_bit_valid (tx_bit_valid),
        .echo         (echo),
        .bus_drive    (bus_drive),
        .bus_grant    (bus_grant),
        .collision    (collision)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int clamp_base(int b);
        if (b < 7)  return 7;
        if (b > 10) return 10;
        return b;
    endfunction

    // Holds the bus at 0, optionally shows a short run of ones that is broken
    // by a 0, then releases the bus and counts edges until the grant.
    task automatic run_access(int exp_thr, string req, int glitch);
        int n;
        bit got;
        tx_bit_valid = 1'b1;
        tx_bit       = 1'b1;
        other_bit    = 1'b0;
        force_one    = 1'b0;
        step();
        step();
        chk({req, " no grant on busy bus"}, bus_grant, 0);
        if (glitch > 0) begin
            other_bit = 1'b1;
            for (int i = 0; i < glitch; i++) step();
            chk("R3 no grant on short run", bus_grant, 0);
            other_bit = 1'b0;
            step();
        end
        other_bit = 1'b1;
        n   = 0;
        got = 1'b0;
        for (int i = 0; i < 16 && !got; i++) begin
            step();
            n++;
            if (bus_grant) got = 1'b1;
        end
        chk({req, " edges to grant"}, n, exp_thr);
    endtask

    task automatic finish_frame();
        tx_bit_valid = 1'b0;
        tx_bit       = 1'b1;
        step();
        chk("R10 grant after request drop", bus_grant, 0);
        chk("R5 drive released when idle", bus_drive, 1);
    endtask

    task automatic collide(int next_thr);
        tx_bit    = 1'b1;
        other_bit = 1'b0;
        step();
        chk("R6 collision pulse", collision, 1);
        chk("R6 grant during collision", bus_grant, 0);
        chk("R6 drive during collision", bus_drive, 1);
        step();
        chk("R6 pulse width", collision, 0);
        run_access(next_thr, "R8", 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n        = 1'b0;
        cfg_run_base = 4'd7;
        tx_bit       = 1'b1;
        tx_bit_valid = 1'b0;
        other_bit    = 1'b1;
        force_one    = 1'b0;
        repeat (3) step();
        chk("R1 grant in reset", bus_grant, 0);
        chk("R1 drive in reset", bus_drive, 1);
        chk("R1 collision in reset", collision, 0);
        rst_n = 1'b1;
        step();

        // R2 and R4: every base value, computed clamp
        for (int b = 0; b < 16; b++) begin
            cfg_run_base = 4'(b);
            run_access(clamp_base(b), "R2 R4", 0);
            finish_frame();
        end

        // R8 and R9: repeated collisions for each legal base, then recovery
        for (int b = 7; b <= 10; b++) begin
            cfg_run_base = 4'(b);
            run_access(b, "R2", 0);
            for (int k = 1; k <= 4; k++) begin
                collide((b + k > 10) ? 10 : b + k);
            end
            finish_frame();
            run_access(b, "R9", 0);
            finish_frame();
        end

        // R3: broken runs restart the count
        cfg_run_base = 4'd8;
        for (int g = 1; g < 8; g++) begin
            run_access(8, "R3", g);
            finish_frame();
        end

        // R5: drive follows data while granted
        cfg_run_base = 4'd7;
        run_access(7, "R5", 0);
        for (int i = 0; i < 8; i++) begin
            logic [7:0] pat;
            pat    = 8'b1001_0110;
            tx_bit = pat[i];
            #1;
            chk("R5 drive follows data", bus_drive, pat[i]);
            step();
            chk("R5 grant held", bus_grant, 1);
            chk("R5 no collision on clean echo", collision, 0);
        end

        // R7: driving 0 with either echo level
        tx_bit    = 1'b0;
        force_one = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R7 no collision with echo 1", collision, 0);
            chk("R7 grant kept", bus_grant, 1);
        end
        force_one = 1'b0;
        other_bit = 1'b0;
        step();
        chk("R7 no collision with echo 0", collision, 0);
        chk("R7 grant kept", bus_grant, 1);
        other_bit = 1'b1;
        finish_frame();

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule